// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Core

This block keeps the interrupt state of one processor: a 256-bit pending set, a 256-bit in-service set and a 256-bit trigger-mode set. Each is indexed by an 8-bit vector, and vector v sits at bit v&31 of 32-bit word v>>5. Incoming requests are accepted into the pending set. A processor priority is derived from a task priority value and the class (upper four bits) of the highest vector in service. The highest pending vector is offered to the processor only when its class beats that priority.

The processor takes a vector with an acknowledge request. That moves the vector from pending to in service, and the vector comes back one cycle later. An end-of-interrupt strobe retires the highest in-service vector. When that vector was level-triggered, it is also announced on a broadcast output so that the upstream source can re-arm. All responses are registered and appear one clock after the request.

Top module: `vec_irq_core`

## Requirements
- R1: After reset the pending, in-service and trigger-mode sets, the task priority and the processor priority are all zero. No vector is deliverable, and an acknowledge returns "none".
- R2: While `enable` is high, a request on the accept port sets the vector's pending bit. It loads the trigger-mode bit with `acc_level` (1 = level, 0 = edge) and pulses `acc_ok` in the next cycle.
- R3: A level request for a vector whose pending bit is already set is dropped (`acc_drop` pulses). An edge request for a pending vector is accepted.
- R4: While `enable` is low, every request is dropped and an acknowledge returns "none".
- R5: `irq_vector` shows the index of the most significant set pending bit, or 0 when none is set. An acknowledge always takes that vector.
- R6: `ppr_q` equals the task priority when the task priority's class is greater than or equal to the class of the highest in-service vector; otherwise it equals that vector with its low four bits cleared. An empty in-service set counts as vector 0. `ppr_q` follows its inputs one cycle later.
- R7: `irq_pending` is high only when enabled and ({class of highest pending, 4'b0}) > `ppr_q`. An equal class does not deliver.
- R8: An acknowledge with a deliverable vector sets its in-service bit, clears its pending bit and returns it on `ack_vector` with `ack_vld` high and `ack_none` low one cycle later. Otherwise `ack_vld` comes with `ack_none` high.
- R9: An EOI clears the highest in-service bit. If that vector's trigger-mode bit was set, it clears the bit and pulses `eoi_bc_valid` with the vector on the next cycle. An EOI with nothing in service changes nothing.
- R10: `tpr_we` loads the task priority with the 8-bit value. `tpr_nib_we` loads it with the 4-bit value shifted left by four. If both are high in one cycle, the 8-bit write wins.
- R11: Vectors below 16 are still accepted but raise `acc_lowvec` with the response, and they are never deliverable.
- R12: When an accept and an acknowledge fall in the same cycle, the acknowledge works from the state before that edge. An accept of the vector being acknowledged leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| acc_valid | input | 1 | Accept request strobe |
| acc_vector | input | 8 | Requested vector |
| acc_level | input | 1 | 1 = level, 0 = edge |
| acc_ok | output | 1 | Request accepted (next cycle) |
| acc_drop | output | 1 | Request dropped (next cycle) |
| acc_lowvec | output | 1 | Request carried a vector below 16 |
| tpr_we | input | 1 | Full task priority write |
| tpr_wdata | input | 8 | Task priority value |
| tpr_nib_we | input | 1 | 4-bit task priority write |
| tpr_nib | input | 4 | Class written to task priority[7:4] |
| tpr_q | output | 8 | Task priority |
| ppr_q | output | 8 | Processor priority |
| ack_req | input | 1 | Acknowledge request |
| ack_vld | output | 1 | Acknowledge response |
| ack_none | output | 1 | No deliverable vector |
| ack_vector | output | 8 | Acknowledged vector |
| eoi_strobe | input | 1 | End of interrupt |
| eoi_bc_valid | output | 1 | Level EOI broadcast pulse |
| eoi_bc_vector | output | 8 | Broadcast vector |
| irq_pending | output | 1 | A deliverable vector exists |
| irq_vector | output | 8 | Highest pending vector |

## Verification
The acknowledge and the accept port can act in the same clock, and both may name the same vector. The bench first leaves a vector pending. It then raises an edge request for that vector together with an acknowledge request in a single cycle. The outcome is judged at the ports: the acknowledge must return the vector while the accept reports success, and the vector must still show as highest pending afterwards. It must stay blocked until an EOI lowers the priority, and then it can be acknowledged again.

// File: rtl/vec_irq_core.sv
module vec_irq_core #(
  parameter int VW    = 8,
  parameter int WORDW = 32,
  parameter int LOWV  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          acc_valid,
  input  logic [VW-1:0] acc_vector,
  input  logic          acc_level,
  output logic          acc_ok,
  output logic          acc_drop,
  output logic          acc_lowvec,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          tpr_nib_we,
  input  logic [3:0]    tpr_nib,
  output logic [VW-1:0] tpr_q,
  output logic [VW-1:0] ppr_q,
  input  logic          ack_req,
  output logic          ack_vld,
  output logic          ack_none,
  output logic [VW-1:0] ack_vector,
  input  logic          eoi_strobe,
  output logic          eoi_bc_valid,
  output logic [VW-1:0] eoi_bc_vector,
  output logic          irq_pending,
  output logic [VW-1:0] irq_vector
);
  localparam int NV    = 1 << VW;
  localparam int NWORD = NV / WORDW;
  localparam logic [VW-1:0] CLS = {4'hF, {(VW-4){1'b0}}};

  logic [NV-1:0] pend_q, isr_q, tmr_q;
  logic [NV-1:0] pend_n, isr_n, tmr_n;

  function automatic logic [VW:0] top_bit(input logic [NV-1:0] b);
    logic [VW:0] r;
    r = '0;
    for (int w = 0; w < NWORD; w++)
      if (|b[w*WORDW +: WORDW])
        for (int i = 0; i < WORDW; i++)
          if (b[w*WORDW+i]) r = {1'b1, VW'(w*WORDW+i)};
    return r;
  endfunction

  logic [VW:0]   hp, hs;
  logic [VW-1:0] hp_v, hs_v, isrv, ppr_nxt;
  logic          deliver, acc_take, ack_go, eoi_go;

  assign hp   = top_bit(pend_q);
  assign hs   = top_bit(isr_q);
  assign hp_v = hp[VW-1:0];
  assign hs_v = hs[VW-1:0];
  assign isrv = hs[VW] ? hs_v : '0;

  assign ppr_nxt  = ((tpr_q & CLS) >= (isrv & CLS)) ? tpr_q : (isrv & CLS);
  assign deliver  = enable && hp[VW] && ((hp_v & CLS) > ppr_q);
  assign acc_take = acc_valid && enable && !(pend_q[acc_vector] && acc_level);
  assign ack_go   = ack_req && deliver;
  assign eoi_go   = eoi_strobe && hs[VW];

  assign irq_pending = deliver;
  assign irq_vector  = hp[VW] ? hp_v : '0;

  always_comb begin
    pend_n = pend_q;
    isr_n  = isr_q;
    tmr_n  = tmr_q;
    if (ack_go) begin
      pend_n[hp_v] = 1'b0;
      isr_n[hp_v]  = 1'b1;
    end
    if (eoi_go) begin
      isr_n[hs_v] = 1'b0;
      tmr_n[hs_v] = 1'b0;
    end
    if (acc_take) begin
      pend_n[acc_vector] = 1'b1;
      tmr_n[acc_vector]  = acc_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q        <= '0;
      isr_q         <= '0;
      tmr_q         <= '0;
      tpr_q         <= '0;
      ppr_q         <= '0;
      acc_ok        <= 1'b0;
      acc_drop      <= 1'b0;
      acc_lowvec    <= 1'b0;
      ack_vld       <= 1'b0;
      ack_none      <= 1'b0;
      ack_vector    <= '0;
      eoi_bc_valid  <= 1'b0;
      eoi_bc_vector <= '0;
    end else begin
      pend_n_hold: begin
        pend_q <= pend_n;
        isr_q  <= isr_n;
        tmr_q  <= tmr_n;
      end
      if (tpr_we)          tpr_q <= tpr_wdata;
      else if (tpr_nib_we) tpr_q <= {tpr_nib, {(VW-4){1'b0}}};
      ppr_q         <= ppr_nxt;
      acc_ok        <= acc_take;
      acc_drop      <= acc_valid && !acc_take;
      acc_lowvec    <= acc_valid && (acc_vector < VW'(LOWV));
      ack_vld       <= ack_req;
      ack_none      <= ack_req && !ack_go;
      ack_vector    <= ack_go ? hp_v : '0;
      eoi_bc_valid  <= eoi_go && tmr_q[hs_v];
      eoi_bc_vector <= (eoi_go && tmr_q[hs_v]) ? hs_v : '0;
    end
  end
endmodule

// File: rtl/vec_irq_core_chk.sv
module vec_irq_core_chk #(
  parameter int VW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 acc_valid,
  input logic                 acc_ok,
  input logic                 acc_drop,
  input logic                 ack_req,
  input logic                 ack_vld,
  input logic                 ack_none,
  input logic [VW-1:0]        ack_vector,
  input logic                 eoi_strobe,
  input logic                 eoi_bc_valid,
  input logic                 irq_pending,
  input logic [VW-1:0]        irq_vector,
  input logic [VW-1:0]        tpr_q,
  input logic [VW-1:0]        ppr_q,
  input logic [(1<<VW)-1:0]   isr_q
);
  localparam int NV = 1 << VW;

  logic [VW-1:0] top_isr, exp_ppr;
  always_comb begin
    top_isr = '0;
    for (int k = NV-1; k >= 0; k--)
      if (isr_q[k] && top_isr == '0) top_isr = VW'(k);
    if (tpr_q[VW-1:VW-4] >= top_isr[VW-1:VW-4]) exp_ppr = tpr_q;
    else exp_ppr = {top_isr[VW-1:VW-4], {(VW-4){1'b0}}};
  end

  // R2
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> $onehot({acc_ok, acc_drop}));

  // R4
  disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !enable) |=> acc_drop);

  // R8
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_vld);

  // R11
  no_low_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !ack_none) |-> (ack_vector >= VW'(16)));

  // R9
  bcast_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bc_valid |-> $past(eoi_strobe));

  // R6
  ppr_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_q == $past(exp_ppr));

  // R7
  deliver_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (enable && ({irq_vector[VW-1:VW-4], {(VW-4){1'b0}}} > ppr_q)));
endmodule

bind vec_irq_core vec_irq_core_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .acc_valid(acc_valid), .acc_ok(acc_ok), .acc_drop(acc_drop),
  .ack_req(ack_req), .ack_vld(ack_vld), .ack_none(ack_none), .ack_vector(ack_vector),
  .eoi_strobe(eoi_strobe), .eoi_bc_valid(eoi_bc_valid),
  .irq_pending(irq_pending), .irq_vector(irq_vector),
  .tpr_q(tpr_q), .ppr_q(ppr_q), .isr_q(isr_q)
);

// File: tb/vec_irq_core_tb.sv
module vec_irq_core_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic acc_valid = 1'b0, acc_level = 1'b0;
  logic [7:0] acc_vector = '0;
  logic acc_ok, acc_drop, acc_lowvec;
  logic tpr_we = 1'b0, tpr_nib_we = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic [3:0] tpr_nib = '0;
  logic [7:0] tpr_q, ppr_q;
  logic ack_req = 1'b0, ack_vld, ack_none;
  logic [7:0] ack_vector;
  logic eoi_strobe = 1'b0, eoi_bc_valid;
  logic [7:0] eoi_bc_vector;
  logic irq_pending;
  logic [7:0] irq_vector;

  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  vec_irq_core u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
    .acc_ok(acc_ok), .acc_drop(acc_drop), .acc_lowvec(acc_lowvec),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_nib_we(tpr_nib_we), .tpr_nib(tpr_nib),
    .tpr_q(tpr_q), .ppr_q(ppr_q),
    .ack_req(ack_req), .ack_vld(ack_vld), .ack_none(ack_none), .ack_vector(ack_vector),
    .eoi_strobe(eoi_strobe), .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vector(eoi_bc_vector),
    .irq_pending(irq_pending), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_accept(input logic [7:0] v, input logic lvl,
                           output logic ok, output logic drop, output logic low);
    @(negedge clk);
    acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
    @(negedge clk);
    acc_valid = 1'b0;
    ok = acc_ok; drop = acc_drop; low = acc_lowvec;
  endtask

  task automatic do_ack(output logic vld, output logic none, output logic [7:0] vec);
    @(negedge clk);
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
    vld = ack_vld; none = ack_none; vec = ack_vector;
  endtask

  task automatic do_eoi(output logic bc, output logic [7:0] vec);
    @(negedge clk);
    eoi_strobe = 1'b1;
    @(negedge clk);
    eoi_strobe = 1'b0;
    bc = eoi_bc_valid; vec = eoi_bc_vector;
  endtask

  task automatic do_tpr(input logic [7:0] d);
    @(negedge clk);
    tpr_we = 1'b1; tpr_wdata = d;
    @(negedge clk);
    tpr_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_nib(input logic [3:0] n);
    @(negedge clk);
    tpr_nib_we = 1'b1; tpr_nib = n;
    @(negedge clk);
    tpr_nib_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic v, n; logic [7:0] x;
    chk("R1", "tpr", tpr_q, 0);
    chk("R1", "ppr", ppr_q, 0);
    chk("R1", "irq_pending", irq_pending, 0);
    chk("R1", "irq_vector", irq_vector, 0);
    do_ack(v, n, x);
    chk("R1", "ack none after reset", {v, n}, 2'b11);
  endtask

  task automatic t_basic();
    logic ok, dr, lo, v, n, bc; logic [7:0] x;
    do_accept(8'h45, 1'b0, ok, dr, lo);
    chk("R2", "accept ok/drop", {ok, dr}, 2'b10);
    chk("R5", "highest pending", irq_vector, 8'h45);
    chk("R7", "deliverable", irq_pending, 1);
    do_ack(v, n, x);
    chk("R8", "ack result", {v, n, x}, {2'b10, 8'h45});
    idle(1);
    chk("R6", "ppr from in-service", ppr_q, 8'h40);
    chk("R8", "pending cleared", irq_vector, 0);
    do_eoi(bc, x);
    chk("R9", "edge eoi no broadcast", bc, 0);
    idle(1);
    chk("R9", "ppr after eoi", ppr_q, 0);
  endtask

  task automatic t_priority();
    logic ok, dr, lo, v, n, bc; logic [7:0] x;
    do_accept(8'h61, 1'b0, ok, dr, lo);
    do_accept(8'h9A, 1'b0, ok, dr, lo);
    chk("R5", "highest of two", irq_vector, 8'h9A);
    do_ack(v, n, x);
    chk("R5", "ack takes highest", x, 8'h9A);
    idle(1);
    chk("R6", "ppr class 9", ppr_q, 8'h90);
    chk("R7", "lower class blocked", {irq_pending, irq_vector}, {1'b0, 8'h61});
    do_eoi(bc, x);
    idle(1);
    chk("R7", "unblocked after eoi", irq_pending, 1);
    do_ack(v, n, x);
    chk("R8", "second ack", {v, n, x}, {2'b10, 8'h61});
    do_eoi(bc, x);
    idle(1);
  endtask

  task automatic t_tpr();
    logic ok, dr, lo, v, n, bc; logic [7:0] x;
    do_tpr(8'hA0);
    chk("R6", "ppr follows tpr", ppr_q, 8'hA0);
    do_accept(8'hA5, 1'b0, ok, dr, lo);
    chk("R7", "equal class blocked", irq_pending, 0);
    do_tpr(8'h52);
    chk("R6", "ppr low tpr", ppr_q, 8'h52);
    chk("R7", "higher class delivers", irq_pending, 1);
    do_ack(v, n, x);
    idle(1);
    chk("R6", "isr class wins", ppr_q, 8'hA0);
    do_nib(4'h7);
    chk("R10", "nibble write", tpr_q, 8'h70);
    do_tpr(8'hB3);
    chk("R6", "tpr class wins over isr", ppr_q, 8'hB3);
    @(negedge clk);
    tpr_we = 1'b1; tpr_wdata = 8'h12; tpr_nib_we = 1'b1; tpr_nib = 4'hF;
    @(negedge clk);
    tpr_we = 1'b0; tpr_nib_we = 1'b0;
    chk("R10", "full write wins", tpr_q, 8'h12);
    do_eoi(bc, x);
    do_tpr(8'h00);
  endtask

  task automatic t_level();
    logic ok, dr, lo, v, n, bc; logic [7:0] x;
    do_accept(8'h70, 1'b0, ok, dr, lo);
    do_accept(8'h70, 1'b1, ok, dr, lo);
    chk("R3", "level repeat dropped", {ok, dr}, 2'b01);
    do_accept(8'h70, 1'b0, ok, dr, lo);
    chk("R3", "edge repeat accepted", {ok, dr}, 2'b10);
    do_accept(8'h33, 1'b1, ok, dr, lo);
    chk("R2", "level accept", {ok, dr}, 2'b10);
    do_ack(v, n, x);
    do_eoi(bc, x);
    chk("R9", "edge vector no broadcast", bc, 0);
    idle(1);
    do_ack(v, n, x);
    chk("R8", "ack level vector", x, 8'h33);
    do_eoi(bc, x);
    chk("R9", "level broadcast", {bc, x}, {1'b1, 8'h33});
    do_eoi(bc, x);
    chk("R9", "empty eoi", bc, 0);
    idle(1);
    chk("R9", "empty eoi state", {ppr_q, irq_vector}, 16'h0);
  endtask

  task automatic t_disabled();
    logic ok, dr, lo, v, n, bc; logic [7:0] x;
    do_accept(8'h50, 1'b0, ok, dr, lo);
    enable = 1'b0;
    do_accept(8'h60, 1'b0, ok, dr, lo);
    chk("R4", "disabled drop", {ok, dr}, 2'b01);
    do_ack(v, n, x);
    chk("R4", "disabled ack none", {v, n}, 2'b11);
    chk("R4", "disabled not deliverable", irq_pending, 0);
    enable = 1'b1;
    idle(1);
    chk("R4", "dropped not pending", irq_vector, 8'h50);
    do_ack(v, n, x);
    do_eoi(bc, x);
    idle(1);
  endtask

  task automatic t_low();
    logic ok, dr, lo, v, n; logic [7:0] x;
    do_accept(8'h05, 1'b0, ok, dr, lo);
    chk("R11", "low vector flagged", {ok, lo}, 2'b11);
    chk("R11", "low vector not deliverable", {irq_pending, irq_vector}, {1'b0, 8'h05});
    do_ack(v, n, x);
    chk("R11", "low vector ack none", {v, n}, 2'b11);
  endtask

  task automatic t_same();
    logic ok, dr, lo, v, n, bc; logic [7:0] x;
    do_accept(8'h88, 1'b0, ok, dr, lo);
    @(negedge clk);
    acc_valid = 1'b1; acc_vector = 8'h88; acc_level = 1'b0; ack_req = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; ack_req = 1'b0;
    chk("R12", "ack in same cycle", {ack_vld, ack_none, ack_vector}, {2'b10, 8'h88});
    chk("R12", "accept in same cycle", acc_ok, 1);
    chk("R12", "still pending", irq_vector, 8'h88);
    idle(1);
    chk("R12", "blocked while in service", irq_pending, 0);
    do_eoi(bc, x);
    idle(1);
    do_ack(v, n, x);
    chk("R12", "re-ack", {v, n, x}, {2'b10, 8'h88});
    do_eoi(bc, x);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_priority();
    t_tpr();
    t_level();
    t_disabled();
    t_low();
    t_same();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule